// File: doc/BRIEF.md
# Memory-mapped BCD real-time clock

This block keeps calendar time and presents it to a host as eight ordinary bytes at the very top of a 19-bit, byte-wide SRAM-style address range. The host uses the usual active-low chip, write and output enables, with separate input and output data buses. Any address below the clock window is passed on to an external SRAM array through a dedicated active-low select. The block drives its output bus only for reads of its own window.

Seven internal counters hold seconds, minutes, hours, day of week, date, month and a two-digit year in packed BCD. A synchronous, one-cycle 1 Hz enable advances them. The host never reads the counters directly. It reads and writes a bank of copy registers, which are refreshed from the counters in the same cycle as each tick. The host bus has no ready or stall signal. A host access completes in its own cycle whatever the refresh logic is doing. A control byte holds two bits. The read-hold bit freezes the copies so that a multi-byte read is coherent. The write-hold bit lets software stage a new time in the copies and commit it all at once. When the supply-good input is low, the whole block deselects itself.

Top module: `rtc_bcd_mmap`

## Requirements
- R1: Byte addresses 0x7FFF8 to 0x7FFFF form the clock window. The low three address bits select the byte: 0 control, 1 seconds, 2 minutes, 3 hours (00-23), 4 day of week (1-7), 5 date, 6 month, 7 year (00-99). For any other address, with chip enable low and supply good, `sram_ce_n` goes low. `sram_ce_n` stays high for the clock window.
- R2: `dout_en` is high only when supply is good, the address is in the clock window, `ce_n` and `oe_n` are low and `we_n` is high. In that case `dout` shows the addressed byte combinationally. In all other cases `dout` is 0x00.
- R3: After reset, the counters and copies read 00:00:00, day 01, date 01, month 01, year 00, and the control byte reads 0x00.
- R4: Each tick with write hold clear advances seconds. Seconds and minutes wrap from 59 to 00, hours from 23 to 00, and day of week from 7 to 1. Each wrap carries into the next field. An hours wrap advances both day of week and date.
- R5: Date wraps to 01 and carries into month after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4, and 28 days otherwise. All other months have 31 days. Month wraps from 12 to 01 and carries into year.
- R6: Year wraps from 99 to 00.
- R7: When read hold (control bit 6) and write hold (control bit 7) are both clear, every tick loads all seven copies with the newly advanced counter values. Without a tick or a host write to the window, the copies do not change.
- R8: A host write to a clock byte in the same cycle as a tick lands in that byte, and the refresh is skipped for that byte only. SRAM selects are not delayed by a tick.
- R9: While `pwr_ok` is low, host writes are ignored, `dout_en` is 0 and `sram_ce_n` is 1.
- R10: While read hold is set, the copies hold still and the counters keep counting. After read hold is cleared, the next tick shows the fully counted time.
- R11: While write hold is set, the counters stop and host writes reach only the copies. Writing control with bit 7 cleared loads all seven copies into the counters. A tick in that same cycle is discarded.
- R12: Values that are not valid BCD are stored as written. On advance, a field whose value is at or above its limit wraps to its minimum and carries. A field whose low digit is 9 or more becomes (tens+1) with a units digit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle time-advance enable |
| pwr_ok | input | 1 | Supply good; low deselects everything |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data for clock bytes |
| dout_en | output | 1 | Output drive enable |
| sram_ce_n | output | 1 | Active-low select for the external SRAM |

## Verification
The once-per-second copy refresh and a host access can fall in the same cycle. The bench provokes this by asserting `tick_1hz` together with a write to the seconds byte. It then reads the byte back and expects the written value, not the counted one. The next tick must show the counter's own value. The bench also pairs a tick with an SRAM read, and with the write-hold release. In the release case the discarded tick must leave the loaded seconds unchanged. A behavioural model compares `dout`, `dout_en` and `sram_ce_n` on every cycle.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int NFIELD = 7;
  localparam int NREG   = NFIELD + 1;
  localparam int OFFW   = $clog2(NREG);
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [7:0] bcd_t;

  // BCD increment; an out-of-range units digit carries into tens
  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic bcd_t days_in(input bcd_t mon, input bcd_t yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_lim(input int idx, input bcd_t mon, input bcd_t yr);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_DATE:       return days_in(mon, yr);
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic bcd_t field_min(input int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
  parameter int AW   = 19,
  parameter int OFFW = 3
) (
  input  logic [AW-1:0]   addr,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic            pwr_ok,
  output logic [OFFW-1:0] off,
  output logic            wr_en,
  output logic            rd_en,
  output logic            sram_ce_n
);
  logic sel, hit;
  assign sel       = pwr_ok & ~ce_n;
  assign hit       = &addr[AW-1:OFFW];
  assign off       = addr[OFFW-1:0];
  assign wr_en     = sel & hit & ~we_n;
  assign rd_en     = sel & hit & we_n & ~oe_n;
  assign sram_ce_n = ~(sel & ~hit);
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_bcd_pkg::*;
#(
  parameter int NF = NFIELD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               load,
  input  logic [NF-1:0][7:0] load_val,
  output logic [NF-1:0][7:0] cnt,
  output logic [NF-1:0][7:0] nxt
);
  logic [NF-1:0] cin, wrap;

  for (genvar i = 0; i < NF; i++) begin : g_field
    if (i == 0) begin : g_first
      assign cin[i] = adv;
    end else if (i == F_DOW || i == F_DATE) begin : g_day
      assign cin[i] = cin[F_HOUR] & wrap[F_HOUR];
    end else if (i == F_MON) begin : g_mon
      assign cin[i] = cin[F_DATE] & wrap[F_DATE];
    end else begin : g_chain
      assign cin[i] = cin[i-1] & wrap[i-1];
    end

    assign wrap[i] = cnt[i] >= field_lim(i, cnt[F_MON], cnt[F_YEAR]);
    assign nxt[i]  = !cin[i] ? cnt[i] :
                     wrap[i] ? field_min(i) : bcd_inc(cnt[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt[i] <= field_min(i);
      else if (load) cnt[i] <= load_val[i];
      else           cnt[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_bcd_pkg::*;
#(
  parameter int NF = NFIELD,
  parameter int OW = OFFW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [OW-1:0]      off,
  input  logic [7:0]         din,
  input  logic               tick,
  input  logic [NF-1:0][7:0] nxt,
  output logic [7:0]         ctrl,
  output logic [NF-1:0][7:0] cp,
  output logic               commit
);
  logic refresh, ctrl_wr;

  assign ctrl_wr = wr_en && off == '0;
  assign commit  = ctrl_wr && ctrl[7] && !din[7];
  assign refresh = tick && !ctrl[6] && !ctrl[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= 8'h00;
    else if (ctrl_wr) ctrl <= din;
  end

  for (genvar i = 0; i < NF; i++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cp[i] <= field_min(i);
      else if (wr_en && off == OW'(i + 1))      cp[i] <= din;
      else if (refresh)                         cp[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/rtc_bcd_mmap.sv
module rtc_bcd_mmap
  import rtc_bcd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          pwr_ok,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          sram_ce_n
);
  logic [OFFW-1:0]       off;
  logic                  wr_en, rd_en, commit, adv;
  logic [7:0]            ctrl;
  logic [NFIELD-1:0][7:0] cp, cnt, nxt;
  logic [8*NREG-1:0]     copy_flat;
  logic [8*NFIELD-1:0]   cnt_flat;

  rtc_bus_decode #(.AW(AW), .OFFW(OFFW)) u_dec (
    .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .pwr_ok(pwr_ok),
    .off(off), .wr_en(wr_en), .rd_en(rd_en), .sram_ce_n(sram_ce_n)
  );

  // counters freeze under write hold; a tick in the commit cycle is dropped
  assign adv = tick_1hz & ~ctrl[7] & ~commit;

  rtc_time_chain #(.NF(NFIELD)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(commit),
    .load_val(cp), .cnt(cnt), .nxt(nxt)
  );

  rtc_shadow_bank #(.NF(NFIELD), .OW(OFFW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .off(off), .din(din),
    .tick(tick_1hz), .nxt(nxt), .ctrl(ctrl), .cp(cp), .commit(commit)
  );

  always_comb begin
    dout = 8'h00;
    if (rd_en) dout = (off == '0) ? ctrl : cp[off - OFFW'(1)];
  end
  assign dout_en = rd_en;

  assign copy_flat = {cp, ctrl};
  assign cnt_flat  = cnt;
endmodule

// File: rtl/rtc_bcd_mmap_chk.sv
module rtc_bcd_mmap_chk #(
  parameter int AW   = 19,
  parameter int OFFW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1hz,
  input logic          pwr_ok,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [7:0]    din,
  input logic          dout_en,
  input logic          sram_ce_n,
  input logic [63:0]   copy_flat,
  input logic [55:0]   cnt_flat
);
  logic in_win, host_wr;
  assign in_win  = &addr[AW-1:OFFW];
  assign host_wr = pwr_ok & ~ce_n & ~we_n & in_win;

  p_sram_off_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> sram_ce_n);
  p_drive_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n && we_n && in_win && pwr_ok));
  p_copies_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !host_wr) |=> $stable(copy_flat));
  p_host_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && addr[OFFW-1:0] == 3'd1) |=> (copy_flat[15:8] == $past(din)));
  p_supply_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (sram_ce_n && !dout_en));
  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_flat[6] && !host_wr) |=> $stable(copy_flat));
  p_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_flat[7] && !(host_wr && addr[OFFW-1:0] == 3'd0)) |=> $stable(cnt_flat));
endmodule

bind rtc_bcd_mmap rtc_bcd_mmap_chk #(.AW(AW), .OFFW(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_ok(pwr_ok),
  .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
  .dout_en(dout_en), .sram_ce_n(sram_ce_n),
  .copy_flat(copy_flat), .cnt_flat(cnt_flat)
);

// File: tb/rtc_bcd_mmap_bench.sv
module rtc_bcd_mmap_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [18:0] BASE = 19'h7FFF8;
  localparam int WD_LIMIT = 20000;

  logic clk = 0, rst_n = 0, tick_1hz = 0, pwr_ok = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [18:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en, sram_ce_n;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R3";
  int m_cnt[7], m_cp[7], m_ctl;

  rtc_bcd_mmap u_rtc_bcd_mmap (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dec(input int b); return (b >> 4) * 10 + (b & 15); endfunction
  function automatic int lim(input int i);
    case (i)
      0, 1: return 'h59;
      2: return 'h23;
      3: return 'h07;
      4: begin
        if (m_cnt[5] == 'h02) return (dec(m_cnt[6]) % 4 == 0) ? 'h29 : 'h28;
        if (m_cnt[5] inside {'h04, 'h06, 'h09, 'h11}) return 'h30;
        return 'h31;
      end
      5: return 'h12;
      default: return 'h99;
    endcase
  endfunction
  function automatic int lo(input int i); return (i >= 3 && i <= 5) ? 1 : 0; endfunction
  function automatic int inc(input int v);
    if ((v & 15) >= 9) return (((v >> 4) + 1) & 15) << 4;
    return v + 1;
  endfunction
  function automatic int nv(input int i); return (m_cnt[i] >= lim(i)) ? lo(i) : inc(m_cnt[i]); endfunction
  function automatic bit wr_(input int i); return m_cnt[i] >= lim(i); endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int n[7], c[7], o;
    bit hw, rel;
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin m_cnt[i] = lo(i); m_cp[i] = lo(i); end
      m_ctl = 0;
    end else begin
      hw = pwr_ok && !ce_n && !we_n && addr >= BASE;
      o = int'(addr - BASE);
      rel = hw && o == 0 && m_ctl[7] && !din[7];
      n = m_cnt; c = m_cp;
      if (tick_1hz && !m_ctl[7] && !rel) begin
        n[0] = nv(0);
        if (wr_(0)) begin
          n[1] = nv(1);
          if (wr_(1)) begin
            n[2] = nv(2);
            if (wr_(2)) begin
              n[3] = nv(3); n[4] = nv(4);
              if (wr_(4)) begin
                n[5] = nv(5);
                if (wr_(5)) n[6] = nv(6);
              end
            end
          end
        end
      end
      if (tick_1hz && !m_ctl[6] && !m_ctl[7]) c = n;
      if (rel) n = m_cp;
      if (hw && o == 0) m_ctl = din;
      else if (hw) c[o-1] = din;
      m_cnt = n; m_cp = c;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    bit inw, en; int ed, o;
    if (rst_n) begin
      inw = addr >= BASE; o = int'(addr - BASE);
      en = pwr_ok && !ce_n && !oe_n && we_n && inw;
      ed = en ? ((o == 0) ? m_ctl : m_cp[o-1]) : 0;
      chk(dout_en == en, cur_req, dout_en, en);
      chk(dout == ed[7:0], cur_req, dout, ed);
      chk(sram_ce_n == !(pwr_ok && !ce_n && !inw), cur_req, sram_ce_n, !(pwr_ok && !ce_n && !inw));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drv(input bit pw, input bit ce, input bit we, input bit oe,
                     input logic [18:0] a, input logic [7:0] d, input bit tk);
    @(posedge clk); #1;
    pwr_ok = pw; ce_n = ce; we_n = we; oe_n = oe; addr = a; din = d; tick_1hz = tk;
  endtask
  task automatic wr(input int o, input logic [7:0] d); drv(1, 0, 0, 1, BASE + 19'(o), d, 0); endtask
  task automatic tk(); drv(1, 1, 1, 1, '0, '0, 1); endtask
  task automatic rd(input int o, input logic [7:0] exp, input string req);
    drv(1, 0, 1, 0, BASE + 19'(o), '0, 0);
    @(negedge clk);
    chk(dout_en && dout == exp, req, dout, exp);
  endtask
  task automatic set_time(input logic [7:0] s, mi, h, w, d, mo, y);
    wr(0, 8'h80); wr(1, s); wr(2, mi); wr(3, h); wr(4, w); wr(5, d); wr(6, mo); wr(7, y);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3 reset values
    rd(0, 8'h00, "R3"); rd(1, 8'h00, "R3"); rd(4, 8'h01, "R3");
    rd(5, 8'h01, "R3"); rd(6, 8'h01, "R3"); rd(7, 8'h00, "R3");
    // R1 decode, R2 drive rule
    cur_req = "R1";
    drv(1, 0, 1, 0, 19'h00000, '0, 0); @(negedge clk); chk(sram_ce_n == 0, "R1", sram_ce_n, 0);
    drv(1, 0, 1, 0, BASE, '0, 0); @(negedge clk); chk(sram_ce_n == 1, "R1", sram_ce_n, 1);
    cur_req = "R2";
    drv(1, 0, 1, 1, BASE + 19'd1, '0, 0); @(negedge clk);
    chk(!dout_en && dout == 0, "R2", dout_en, 0);
    // R4 R5 R6 full rollover
    cur_req = "R4";
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tk(); rd(1, 8'h59, "R4");
    tk(); rd(1, 8'h00, "R4"); rd(2, 8'h00, "R4"); rd(3, 8'h00, "R4"); rd(4, 8'h01, "R4");
    rd(5, 8'h01, "R5"); rd(6, 8'h01, "R5"); rd(7, 8'h00, "R6");
    cur_req = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    tk(); rd(5, 8'h01, "R5"); rd(6, 8'h03, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tk(); rd(5, 8'h29, "R5"); rd(6, 8'h02, "R5");
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24);
    tk(); rd(5, 8'h01, "R5"); rd(6, 8'h05, "R5");
    // R12 invalid BCD
    cur_req = "R12";
    set_time(8'h7A, 8'h10, 8'h12, 8'h03, 8'h10, 8'h05, 8'h24);
    rd(1, 8'h7A, "R12");
    tk(); rd(1, 8'h00, "R12"); rd(2, 8'h11, "R12");
    set_time(8'h3C, 8'h10, 8'h12, 8'h03, 8'h10, 8'h05, 8'h24);
    tk(); rd(1, 8'h40, "R12");
    // R10 read hold
    cur_req = "R10";
    set_time(8'h10, 8'h20, 8'h12, 8'h03, 8'h10, 8'h05, 8'h24);
    wr(0, 8'h40); tk(); tk(); tk();
    rd(1, 8'h10, "R10"); wr(0, 8'h00); rd(1, 8'h10, "R10");
    tk(); rd(1, 8'h14, "R10");
    // R11 write hold and commit
    cur_req = "R11";
    wr(0, 8'h80); tk(); tk(); wr(0, 8'h00);
    tk(); rd(1, 8'h15, "R11");
    wr(0, 8'h80); wr(1, 8'h30); drv(1, 0, 0, 1, BASE, 8'h00, 1);
    rd(1, 8'h30, "R11"); tk(); rd(1, 8'h31, "R11");
    // R7 refresh overwrites copy-only write
    cur_req = "R7";
    wr(1, 8'h05); rd(1, 8'h05, "R7"); tk(); rd(1, 8'h32, "R7");
    // R8 collisions
    cur_req = "R8";
    drv(1, 0, 0, 1, BASE + 19'd1, 8'h44, 1);
    rd(1, 8'h44, "R8"); tk(); rd(1, 8'h34, "R8");
    drv(1, 0, 1, 0, 19'h12345, '0, 1); @(negedge clk);
    chk(sram_ce_n == 0, "R8", sram_ce_n, 0);
    rd(1, 8'h35, "R8");
    // R9 supply loss
    cur_req = "R9";
    drv(0, 0, 0, 1, BASE + 19'd1, 8'h77, 0); @(negedge clk);
    chk(sram_ce_n == 1, "R9", sram_ce_n, 1);
    drv(0, 0, 1, 0, BASE + 19'd1, '0, 0); @(negedge clk);
    chk(!dout_en && dout == 0, "R9", dout, 0);
    drv(0, 0, 1, 0, 19'h00100, '0, 0); @(negedge clk);
    chk(sram_ce_n == 1, "R9", sram_ce_n, 1);
    rd(1, 8'h35, "R9");
    drv(1, 1, 1, 1, '0, '0, 0);
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule